// File: doc/BRIEF.md
# Temperature-Driven Fan Duty Controller

This block turns one chosen temperature reading into a fan drive signal. A 3-bit selector picks the controlling channel out of several signed 8-bit temperature inputs. The chosen reading is placed on a piecewise-linear curve. Below a start temperature the fan is either stopped or held at a floor duty. Above that point the duty climbs from the floor to full scale across a programmable span. A hysteresis band keeps the fan from switching on and off repeatedly around the start point.

A critical limit, or an unused selector code, overrides the curve and drives full speed. The result is capped by a programmable ceiling except under that override. It is then driven on one pin by an 8-bit PWM counter whose duty register loads only when the period ends. The pin polarity can be inverted for fans that read a low level as full drive.

Temperatures and settings are plain level inputs, sampled every clock. They carry no handshake and have no back-pressure. A consumer of the result reads the applied duty or the pin.

Top module: `fan_duty_ctrl`

## Requirements
- R1: Selector code 0 (3'b000) picks `temp_in[0]` (remote sensor 1), code 1 (3'b001) picks `temp_in[1]` (local sensor) and code 2 (3'b010) picks `temp_in[2]` (remote sensor 2). Every other code forces the duty to 255.
- R2: While engaged and with the reading T above the start S, the duty is `min + ((255-min)*(T-S)*6)/W` using integer division. It is 255 once `(T-S)*6 >= W`. W is the span in sixths of a degree, looked up from `range_code` 0..15: 12,15,20,24,30,40,48,60,80,96,120,160,192,240,320,480 (2 °C up to 80 °C).
- R3: One engagement flag is shared by all channels. A reading above S sets it, and a reading below S minus the selected channel's 4-bit hysteresis clears it. Readings in between leave it unchanged, and an unused selector code leaves it unchanged. While engaged with T at or below S, the duty is `duty_min`.
- R4: While not engaged, the duty is 0 when `keep_min` is 0 and `duty_min` when `keep_min` is 1.
- R5: Outside the override of R1 and R6, the duty is capped at `duty_max`.
- R6: If any channel reads strictly above the signed `crit_limit`, the duty is 255 whatever the selector or `duty_max`.
- R7: The PWM counter counts 0..255 and wraps, starting from 0 after reset. `duty_applied` changes only on the clock edge where the counter wraps, and it takes the target value of that edge.
- R8: In one period the pin is at its active level for `duty_applied` of the 256 clocks, or for all 256 when the duty is 255. The active level is high when `invert` is 0 and low when `invert` is 1.
- R9: Reset clears `duty_applied` to 0, clears the engagement flag and restarts the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_in | input | NUM_CH x 8 | Signed temperature per channel, in °C |
| hyst_in | input | NUM_CH x 4 | Hysteresis per channel, in °C |
| src_sel | input | 3 | Controlling channel code |
| t_start | input | 8 | Signed start temperature, in °C |
| range_code | input | 4 | Span code for the ramp |
| duty_min | input | 8 | Floor duty |
| duty_max | input | 8 | Ceiling duty |
| keep_min | input | 1 | Hold the floor duty instead of stopping when disengaged |
| invert | input | 1 | Pin polarity select |
| crit_limit | input | 8 | Signed critical temperature |
| duty_applied | output | 8 | Duty now driving the pin |
| pwm_out | output | 1 | PWM pin |

## Verification
The properties take the settings at the wrap edge to be the ones that decide the loaded duty. The pin properties assume that `invert` does not change between the sampled cycle and the next one. The bench therefore changes inputs only on the negative edge right after a wrap and holds them for two full periods. Within that time it checks that the old duty is still applied in mid-period, then checks the new duty and the pin's active count over one full period. Readings are drawn near the start temperature so that the ramp, the hysteresis band and the off region are all visited. The critical limit is drawn so that it trips only now and then.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int TEMP_W = 8;
  localparam int DUTY_W = 8;
  localparam int SPAN_W = 9;

  function automatic logic [SPAN_W-1:0] span_sixths(input logic [3:0] code);
    case (code)
      4'd0:  span_sixths = 9'd12;
      4'd1:  span_sixths = 9'd15;
      4'd2:  span_sixths = 9'd20;
      4'd3:  span_sixths = 9'd24;
      4'd4:  span_sixths = 9'd30;
      4'd5:  span_sixths = 9'd40;
      4'd6:  span_sixths = 9'd48;
      4'd7:  span_sixths = 9'd60;
      4'd8:  span_sixths = 9'd80;
      4'd9:  span_sixths = 9'd96;
      4'd10: span_sixths = 9'd120;
      4'd11: span_sixths = 9'd160;
      4'd12: span_sixths = 9'd192;
      4'd13: span_sixths = 9'd240;
      4'd14: span_sixths = 9'd320;
      default: span_sixths = 9'd480;
    endcase
  endfunction
endpackage

// File: rtl/fan_engage.sv
module fan_engage
  import fan_pkg::*;
#(
  parameter int HYST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ok,
  input  logic [TEMP_W-1:0] t_sel,
  input  logic [TEMP_W-1:0] t_start,
  input  logic [HYST_W-1:0] hyst,
  output logic              engaged
);
  localparam int EXT_W = TEMP_W + 2;

  logic signed [EXT_W-1:0] t_ext, s_ext, lower;
  logic engaged_d;

  always_comb begin
    t_ext = $signed({{2{t_sel[TEMP_W-1]}}, t_sel});
    s_ext = $signed({{2{t_start[TEMP_W-1]}}, t_start});
    lower = s_ext - $signed(EXT_W'(hyst));
    engaged_d = engaged;
    if (src_ok) begin
      if (t_ext > s_ext)      engaged_d = 1'b1;
      else if (t_ext < lower) engaged_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) engaged <= 1'b0;
    else        engaged <= engaged_d;
  end
endmodule

// File: rtl/fan_curve.sv
module fan_curve
  import fan_pkg::*;
(
  input  logic              override_full,
  input  logic              engaged,
  input  logic              keep_min,
  input  logic [TEMP_W-1:0] t_sel,
  input  logic [TEMP_W-1:0] t_start,
  input  logic [3:0]        range_code,
  input  logic [DUTY_W-1:0] duty_min,
  input  logic [DUTY_W-1:0] duty_max,
  output logic [DUTY_W-1:0] target
);
  localparam int EXT_W  = TEMP_W + 2;
  localparam int D6_W   = TEMP_W + 3;
  localparam int PROD_W = DUTY_W + D6_W;
  localparam logic [DUTY_W-1:0] FULL = '1;

  logic signed [EXT_W-1:0] diff;
  logic [D6_W-1:0]   d6;
  logic [SPAN_W-1:0] w6;
  logic [PROD_W-1:0] num, quo, level;

  always_comb begin
    diff  = $signed({{2{t_sel[TEMP_W-1]}}, t_sel}) - $signed({{2{t_start[TEMP_W-1]}}, t_start});
    d6    = D6_W'(diff[TEMP_W-1:0]) * D6_W'(6);
    w6    = span_sixths(range_code);
    num   = PROD_W'(FULL - duty_min) * PROD_W'(d6);
    quo   = num / PROD_W'(w6);
    if (engaged && diff > 0) begin
      if (d6 >= D6_W'(w6)) level = PROD_W'(FULL);
      else                 level = PROD_W'(duty_min) + quo;
    end else if (engaged || keep_min) begin
      level = PROD_W'(duty_min);
    end else begin
      level = '0;
    end
    if (override_full)                 target = FULL;
    else if (level > PROD_W'(duty_max)) target = duty_max;
    else                               target = level[DUTY_W-1:0];
  end
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] target,
  input  logic              invert,
  output logic [DUTY_W-1:0] duty_q,
  output logic              period_end,
  output logic              pwm_q
);
  localparam logic [DUTY_W-1:0] TOP = '1;

  logic [DUTY_W-1:0] cnt_q;
  logic active;

  assign period_end = (cnt_q == TOP);
  assign active     = (duty_q == TOP) || (cnt_q < duty_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (period_end) duty_q <= target;
      pwm_q <= active ^ invert;
    end
  end
endmodule

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl
  import fan_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int HYST_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CH-1:0][TEMP_W-1:0]  temp_in,
  input  logic [NUM_CH-1:0][HYST_W-1:0]  hyst_in,
  input  logic [2:0]                     src_sel,
  input  logic [TEMP_W-1:0]              t_start,
  input  logic [3:0]                     range_code,
  input  logic [DUTY_W-1:0]              duty_min,
  input  logic [DUTY_W-1:0]              duty_max,
  input  logic                           keep_min,
  input  logic                           invert,
  input  logic [TEMP_W-1:0]              crit_limit,
  output logic [DUTY_W-1:0]              duty_applied,
  output logic                           pwm_out
);
  logic              src_ok, crit_hit, engaged, period_end;
  logic [TEMP_W-1:0] t_sel;
  logic [HYST_W-1:0] h_sel;
  logic [DUTY_W-1:0] target;

  always_comb begin
    src_ok   = 1'b0;
    crit_hit = 1'b0;
    t_sel    = temp_in[0];
    h_sel    = hyst_in[0];
    for (int i = 0; i < NUM_CH; i++) begin
      if (src_sel == 3'(i)) begin
        src_ok = 1'b1;
        t_sel  = temp_in[i];
        h_sel  = hyst_in[i];
      end
      if ($signed(temp_in[i]) > $signed(crit_limit)) crit_hit = 1'b1;
    end
  end

  fan_engage #(.HYST_W(HYST_W)) u_engage (
    .clk(clk), .rst_n(rst_n), .src_ok(src_ok), .t_sel(t_sel),
    .t_start(t_start), .hyst(h_sel), .engaged(engaged)
  );

  fan_curve u_curve (
    .override_full(crit_hit | ~src_ok), .engaged(engaged), .keep_min(keep_min),
    .t_sel(t_sel), .t_start(t_start), .range_code(range_code),
    .duty_min(duty_min), .duty_max(duty_max), .target(target)
  );

  fan_pwm_gen u_pwm (
    .clk(clk), .rst_n(rst_n), .target(target), .invert(invert),
    .duty_q(duty_applied), .period_end(period_end), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/fan_duty_ctrl_chk.sv
module fan_duty_ctrl_chk #(
  parameter int NUM_CH = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0][7:0]  temp_in,
  input logic [2:0]              src_sel,
  input logic [7:0]              crit_limit,
  input logic [7:0]              duty_max,
  input logic                    invert,
  input logic                    period_end,
  input logic [7:0]              duty_applied,
  input logic                    pwm_out
);
  logic hot;
  always_comb begin
    hot = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      if ($signed(temp_in[i]) > $signed(crit_limit)) hot = 1'b1;
  end

  p_hold_mid_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(duty_applied));

  p_crit_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && hot) |=> duty_applied == 8'hFF);

  p_bad_code_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && src_sel > 3'(NUM_CH - 1)) |=> duty_applied == 8'hFF);

  p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !hot && src_sel < 3'(NUM_CH)) |=> duty_applied <= $past(duty_max));

  p_pin_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_applied == 8'hFF) |=> pwm_out == !$past(invert));

  p_pin_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_applied == 8'h00) |=> pwm_out == $past(invert));
endmodule

bind fan_duty_ctrl fan_duty_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .src_sel(src_sel),
  .crit_limit(crit_limit), .duty_max(duty_max), .invert(invert),
  .period_end(period_end), .duty_applied(duty_applied), .pwm_out(pwm_out)
);

// File: tb/tb_fan_duty_ctrl.sv
module tb_fan_duty_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0][7:0] temp_in;
  logic [2:0][3:0] hyst_in;
  logic [2:0] src_sel;
  logic [7:0] t_start, duty_min, duty_max, crit_limit;
  logic [3:0] range_code;
  logic keep_min, invert;
  logic [7:0] duty_applied;
  logic pwm_out;

  int checks = 0;
  int fails = 0;
  int eng_m = 0;
  int prev_exp = 0;
  int t_m[3];
  int h_m[3];
  int start_m, crit_m;

  always #2 clk = ~clk;

  fan_duty_ctrl dut (
    .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .hyst_in(hyst_in),
    .src_sel(src_sel), .t_start(t_start), .range_code(range_code),
    .duty_min(duty_min), .duty_max(duty_max), .keep_min(keep_min),
    .invert(invert), .crit_limit(crit_limit), .duty_applied(duty_applied),
    .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int span6(input int code);
    case (code)
      0: return 12;  1: return 15;  2: return 20;  3: return 24;
      4: return 30;  5: return 40;  6: return 48;  7: return 60;
      8: return 80;  9: return 96;  10: return 120; 11: return 160;
      12: return 192; 13: return 240; 14: return 320; default: return 480;
    endcase
  endfunction

  function automatic int expected_duty();
    int t, v, d6, w;
    for (int i = 0; i < 3; i++) if (t_m[i] > crit_m) return 255;
    if (src_sel > 3'd2) return 255;
    t = t_m[src_sel];
    w = span6(int'(range_code));
    if (eng_m != 0 && t > start_m) begin
      d6 = (t - start_m) * 6;
      if (d6 >= w) v = 255;
      else v = int'(duty_min) + ((255 - int'(duty_min)) * d6) / w;
    end else if (eng_m != 0 || keep_min) v = int'(duty_min);
    else v = 0;
    if (v > int'(duty_max)) v = int'(duty_max);
    return v;
  endfunction

  task automatic drive();
    for (int i = 0; i < 3; i++) begin
      temp_in[i] = 8'(t_m[i]);
      hyst_in[i] = 4'(h_m[i]);
    end
    t_start = 8'(start_m);
    crit_limit = 8'(crit_m);
  endtask

  // Called at the negedge right after a counter wrap; inputs held two periods.
  task automatic step(input string req);
    int e, hi, want;
    drive();
    if (src_sel <= 3'd2) begin
      if (t_m[src_sel] > start_m) eng_m = 1;
      else if (t_m[src_sel] < start_m - h_m[src_sel]) eng_m = 0;
    end
    e = expected_duty();
    repeat (128) @(negedge clk);
    chk("R7 old duty held mid-period", int'(duty_applied), prev_exp);
    repeat (128) @(negedge clk);
    chk(req, int'(duty_applied), e);
    hi = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    want = (e == 255) ? 256 : e;
    if (invert) want = 256 - want;
    chk("R8 pin high count", hi, want);
    prev_exp = e;
  endtask

  function automatic int clip(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_m = '{20, 20, 20};
    h_m = '{5, 5, 5};
    start_m = 40; crit_m = 100;
    src_sel = 3'd1; range_code = 4'd7;
    duty_min = 8'd64; duty_max = 8'd255;
    keep_min = 1'b0; invert = 1'b0;
    drive();
    repeat (3) @(negedge clk);
    chk("R9 reset duty", int'(duty_applied), 0);
    rst_n = 1'b1;

    t_m[1] = 50; step("R2 top of ramp");
    t_m[1] = 45; step("R2 mid ramp");
    t_m[1] = 38; step("R3 band keeps engaged at min");
    t_m[1] = 30; step("R4 off below band");
    t_m[1] = 38; step("R3 band keeps disengaged");
    keep_min = 1'b1; step("R4 keep_min floor");
    keep_min = 1'b0;
    t_m[1] = 45; duty_max = 8'd100; step("R5 ceiling");
    t_m[2] = 110; step("R6 critical override");
    t_m[2] = 20; src_sel = 3'b101; step("R1 unused code");
    src_sel = 3'd0; t_m[0] = 42; duty_max = 8'd255; range_code = 4'd0;
    step("R1 remote1 select");
    src_sel = 3'd2; t_m[2] = 60; range_code = 4'd15; invert = 1'b1;
    step("R8 inverted ramp");
    t_m[2] = 20; step("R8 inverted off");
    invert = 1'b0;

    void'($urandom(32'd7741));
    for (int n = 0; n < 40; n++) begin
      start_m = int'($urandom % 80) - 20;
      for (int i = 0; i < 3; i++) begin
        t_m[i] = clip(start_m + int'($urandom % 50) - 20);
        h_m[i] = int'($urandom % 16);
      end
      crit_m = 80 + int'($urandom % 48);
      src_sel = ($urandom % 8 == 0) ? 3'(3 + $urandom % 5) : 3'($urandom % 3);
      range_code = 4'($urandom);
      duty_min = 8'($urandom);
      duty_max = ($urandom % 4 == 0) ? 8'($urandom) : 8'(128 + $urandom % 128);
      keep_min = 1'($urandom);
      invert = 1'($urandom);
      step("R2 R3 R4 R5 R6 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule